// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one synchronous DRAM burst. A command carries a 9-bit start column, a read/write flag and the burst settings that apply to it. From the next clock onward the block presents one column address per clock until the burst is complete, a stop input cuts it short, or a newer command replaces it. A controller can use it as the data-side address tracker. It can also serve as a reference model for the ordering a memory device applies within a burst.

The command input is a valid-only stream. Commands are taken on every clock in which `cmd_valid` is high, so there is no back-pressure on commands. A command that arrives during a burst ends that burst at once, which allows the column address to change on every clock. The address output is also valid-only. A DRAM burst cannot stall, so the consumer must take each beat in the cycle it is shown.

Burst length, ordering and the single-write mode are sampled only in the cycle a command is accepted. Changing them at any other time has no effect on a burst that is already running.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `col_valid`, `col_last`, `busy` and `col_write` are all low.
- R2: A command accepted on clock edge t gives its first beat in the cycle after t, with `col_addr` equal to `cmd_col` and `col_write` equal to `cmd_write`. `cfg_len`, `cfg_ilv` and `cfg_wsingle` are sampled only at that edge, and their values at any other time have no effect on the burst.
- R3: `cfg_len` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. `col_last` is high on the final beat only, and `col_valid` is low in the cycle after the final beat unless a new command was accepted.
- R4: With `cfg_ilv`=0 (sequential order), beat k of an N-beat burst has the address bits above the low log2(N) bits equal to those of the start column. Its low log2(N) bits are (start + k) mod N, so the sequence wraps inside the aligned window.
- R5: With `cfg_ilv`=1 (interleaved order), beat k keeps the upper bits of the start column. Its low log2(N) bits are start XOR k.
- R6: `cfg_len` codes 4 to 7 select full page. Beat k then has address (start + k) mod 512, and the burst continues until it is stopped or replaced. `col_last` never rises in full page, and `cfg_ilv` is ignored.
- R7: When `cfg_wsingle`=1, a write command gives exactly one beat, with `col_last` high, whatever `cfg_len` is. Read commands still use the programmed length, and with `cfg_wsingle`=0 writes use the programmed length.
- R8: `stop` high in a cycle with no command ends the burst after the beat shown in that cycle, so `col_valid` is low in the next cycle. `stop` while idle has no effect. If `stop` and `cmd_valid` are high together, the new command starts.
- R9: A command accepted while a burst is running abandons the old burst. The next cycle shows the first beat of the new command, so commands on consecutive clocks give one new start column per clock.
- R10: `busy` is high in exactly those cycles in which a burst beat is presented (`col_valid` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted every cycle it is high |
| cmd_col | input | 9 | Start column of the burst |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cfg_len | input | 3 | Burst length code: 0..3 = 1/2/4/8 beats, 4..7 = full page |
| cfg_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| cfg_wsingle | input | 1 | 1 = writes are always one beat |
| stop | input | 1 | Ends the running burst after the current beat |
| col_valid | output | 1 | A beat address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |
| col_write | output | 1 | Direction of the current burst |
| busy | output | 1 | A burst is in progress |

## Verification
The ordering logic is tested with start columns at several offsets inside their window, including starts close to the top of the window and the top of the page. This separates a correct wrap inside the window from a plain increment that carries into the upper bits, and it separates XOR ordering from addition. The full-page run goes past 512 beats with interleaving requested, which shows both the modulo-512 wrap and that the type setting is ignored. The tests for the single-write mode, for stop (during a burst, while idle, and together with a command), and for commands on consecutive clocks separate each way a burst can end from the others. Configuration inputs are changed as soon as each command has been accepted, which shows that they are sampled only at acceptance.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode #(
  parameter int COL_W     = 9,
  parameter int LEN_W     = 3,
  parameter int FULL_CODE = 4
) (
  input  logic [LEN_W-1:0]    len_code,
  input  logic                ilv,
  input  logic                is_write,
  input  logic                wsingle,
  output logic [COL_W-1:0]    win_mask,
  output logic                full_page,
  output burst_col_pkg::order_e order
);
  import burst_col_pkg::*;

  logic single_wr;
  logic full_raw;

  assign single_wr = is_write & wsingle;
  assign full_raw  = (int'(len_code) >= FULL_CODE);
  assign full_page = full_raw & ~single_wr;

  // One mask bit per column bit: the bit is inside the burst window when
  // its index is below the length code, or always in full page.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign win_mask[i] = ~single_wr & (full_raw | (i < int'(len_code)));
  end

  assign order = (ilv && !full_page) ? ORD_ILV : ORD_SEQ;
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic                  cmd_write,
  input  logic                  stop,
  input  logic [COL_W-1:0]      dec_mask,
  input  logic                  dec_full,
  input  burst_col_pkg::order_e dec_order,
  output logic                  active,
  output logic [COL_W-1:0]      start_col,
  output logic [COL_W-1:0]      beat,
  output logic [COL_W-1:0]      mask,
  output burst_col_pkg::order_e order,
  output logic                  wr,
  output logic                  last
);
  import burst_col_pkg::*;

  logic full;

  assign last = active && !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      start_col <= '0;
      beat      <= '0;
      mask      <= '0;
      full      <= 1'b0;
      order     <= ORD_SEQ;
      wr        <= 1'b0;
    end else if (cmd_valid) begin
      active    <= 1'b1;
      start_col <= cmd_col;
      beat      <= '0;
      mask      <= dec_mask;
      full      <= dec_full;
      order     <= dec_order;
      wr        <= cmd_write;
    end else if (active) begin
      if (stop || last) begin
        active <= 1'b0;
        wr     <= 1'b0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R3: a final beat with no new command is followed by an idle cycle
  p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !cmd_valid) |=> !active);
  // R8: stop without a command ends the burst
  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cmd_valid) |=> !active);
  // R7: single-write mode gives a one-beat write
  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && dec_mask == '0 && !dec_full) |=> (active && last));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0]      start_col,
  input  logic [COL_W-1:0]      beat,
  input  logic [COL_W-1:0]      mask,
  input  burst_col_pkg::order_e order,
  output logic [COL_W-1:0]      addr
);
  import burst_col_pkg::*;

  logic [COL_W-1:0] offset;

  always_comb begin
    if (order == ORD_ILV) offset = start_col ^ beat;
    else                  offset = start_col + beat;
    addr = (start_col & ~mask) | (offset & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W     = 9,
  parameter int LEN_W     = 3,
  parameter int FULL_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_write,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_ilv,
  input  logic             cfg_wsingle,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_write,
  output logic             busy
);
  import burst_col_pkg::*;

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  order_e           dec_order;
  logic             active;
  logic [COL_W-1:0] start_col;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask;
  order_e           order;
  logic             wr;
  logic             last;

  burst_cfg_decode #(.COL_W(COL_W), .LEN_W(LEN_W), .FULL_CODE(FULL_CODE)) u_dec (
    .len_code (cfg_len),
    .ilv      (cfg_ilv),
    .is_write (cmd_write),
    .wsingle  (cfg_wsingle),
    .win_mask (dec_mask),
    .full_page(dec_full),
    .order    (dec_order)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_col  (cmd_col),
    .cmd_write(cmd_write),
    .stop     (stop),
    .dec_mask (dec_mask),
    .dec_full (dec_full),
    .dec_order(dec_order),
    .active   (active),
    .start_col(start_col),
    .beat     (beat),
    .mask     (mask),
    .order    (order),
    .wr       (wr),
    .last     (last)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .start_col(start_col),
    .beat     (beat),
    .mask     (mask),
    .order    (order),
    .addr     (col_addr)
  );

  assign col_valid = active;
  assign busy      = active;
  assign col_last  = last;
  assign col_write = wr;

  // R2: an accepted command shows its start column in the next cycle
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));
  // R4/R5: consecutive beats of one burst stay inside the same window
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(col_valid) && !$past(cmd_valid) && col_valid) |->
      ((col_addr & ~mask) == ($past(col_addr) & ~mask)));
  // R6: full-page beats step by one and never flag a last beat
  p_full_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(col_valid) && !$past(cmd_valid) && col_valid && mask == '1) |->
      (col_addr == $past(col_addr) + 1'b1 && !col_last));
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_col = '0;
  logic       cmd_write = 1'b0;
  logic [2:0] cfg_len = '0;
  logic       cfg_ilv = 1'b0;
  logic       cfg_wsingle = 1'b0;
  logic       stop = 1'b0;
  logic       col_valid, col_last, col_write, busy;
  logic [8:0] col_addr;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 1'b0;
  int cycles = 0;

  // reference model state
  int m_active = 0, m_start = 0, m_k = 0, m_len = 0, m_ilv = 0, m_wr = 0;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .cmd_write(cmd_write), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .cfg_wsingle(cfg_wsingle), .stop(stop), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .col_write(col_write), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_addr();
    int base, off;
    if (m_len == 0) return (m_start + m_k) % 512;
    base = m_start - (m_start % m_len);
    off  = m_start % m_len;
    if (m_ilv != 0) return base + (off ^ m_k);
    return base + ((off + m_k) % m_len);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_active = 0; m_wr = 0;
    end else if (cmd_valid) begin
      m_active = 1; m_start = int'(cmd_col); m_k = 0; m_wr = int'(cmd_write);
      m_len = (cfg_len >= 3'd4) ? 0 : (1 << cfg_len);
      if (cmd_write && cfg_wsingle) m_len = 1;
      m_ilv = (cfg_ilv && m_len != 0) ? 1 : 0;
    end else if (m_active != 0) begin
      if (stop) begin
        m_active = 0; m_wr = 0;
      end else if (m_len != 0 && m_k == m_len - 1) begin
        m_active = 0; m_wr = 0;
      end else begin
        m_k++;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(tag, "col_valid", int'(col_valid), m_active);
      check("R10", "busy", int'(busy), m_active);
      if (m_active != 0) begin
        check(tag, "col_addr", int'(col_addr), exp_addr());
        check(tag, "col_last", int'(col_last), (m_len != 0 && m_k == m_len - 1) ? 1 : 0);
        check(tag, "col_write", int'(col_write), m_wr);
      end else begin
        check(tag, "col_last idle", int'(col_last), 0);
        check(tag, "col_write idle", int'(col_write), 0);
      end
    end
  end

  // issue one command for one cycle, then scramble the config inputs (R2)
  task automatic cmd(int col, bit wr, int len, bit ilv, bit ws);
    cmd_valid = 1'b1; cmd_col = 9'(col); cmd_write = wr;
    cfg_len = 3'(len); cfg_ilv = ilv; cfg_wsingle = ws;
    @(negedge clk);
    cmd_valid = 1'b0;
    cfg_len = ~cfg_len; cfg_ilv = ~ilv; cfg_wsingle = ~ws;
    cmd_col = ~cmd_col; cmd_write = ~wr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    tag = "R3";
    for (int l = 0; l < 4; l++) begin cmd(5, 1'b0, l, 1'b0, 1'b0); idle(10); end

    tag = "R4";
    cmd(9'h1FD, 1'b0, 3, 1'b0, 1'b0); idle(10);
    cmd(9'h00E, 1'b1, 2, 1'b0, 1'b0); idle(6);
    cmd(9'h0C3, 1'b0, 1, 1'b0, 1'b0); idle(4);

    tag = "R5";
    cmd(9'h00B, 1'b0, 3, 1'b1, 1'b0); idle(10);
    cmd(9'h1F6, 1'b1, 2, 1'b1, 1'b0); idle(6);
    cmd(9'h0A5, 1'b0, 1, 1'b1, 1'b0); idle(4);

    tag = "R6";
    cmd(9'h1FE, 1'b0, 4, 1'b1, 1'b0); idle(520);
    stop = 1'b1; @(negedge clk); stop = 1'b0; idle(3);
    cmd(9'h010, 1'b1, 7, 1'b0, 1'b0); idle(20);
    stop = 1'b1; @(negedge clk); stop = 1'b0; idle(3);

    tag = "R7";
    cmd(9'h020, 1'b1, 3, 1'b0, 1'b1); idle(5);
    cmd(9'h021, 1'b1, 4, 1'b0, 1'b1); idle(5);
    cmd(9'h022, 1'b0, 2, 1'b0, 1'b1); idle(6);
    cmd(9'h023, 1'b1, 2, 1'b0, 1'b0); idle(6);

    tag = "R8";
    cmd(9'h040, 1'b0, 3, 1'b0, 1'b0); idle(2);
    stop = 1'b1; @(negedge clk); stop = 1'b0; idle(4);
    stop = 1'b1; idle(3); stop = 1'b0; idle(2);
    cmd(9'h050, 1'b0, 3, 1'b0, 1'b0); idle(1);
    stop = 1'b1; cmd(9'h077, 1'b1, 2, 1'b1, 1'b0); stop = 1'b0; idle(6);

    tag = "R9";
    for (int c = 0; c < 6; c++) begin
      cmd_valid = 1'b1; cmd_col = 9'(c * 37 + 3); cmd_write = c[0];
      cfg_len = 3'(c % 5); cfg_ilv = c[1]; cfg_wsingle = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0; idle(10);

    tag = "R2";
    cmd(9'h1FF, 1'b1, 1, 1'b0, 1'b0); idle(1);
    cmd(9'h100, 1'b0, 2, 1'b1, 1'b0); idle(6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule